// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

This block sits next to a processor core and counts what the core does. It has one free-running cycle counter and four event counters. Each event counter chooses one line from a vector of single-cycle event strobes, using an 8-bit code. Software reaches the unit through a simple word-addressed read/write port. To take samples, software preloads a counter with the two's complement of a sample period. When that counter wraps, it sets a sticky overflow flag. If the flag's interrupt enable is set, a level interrupt goes up.

The register map uses word addresses. Address 0 is control, 1 is event select, 2 is interrupt enable and 3 is overflow flags. Address 4 is the cycle counter, and addresses 5 to 8 are event counters 0 to 3. Any other address reads as zero. Register writes take effect at the rising clock edge where `reg_we_i` is high. Reads are combinational from `reg_addr_i`.

To service an overflow, software clears the global enable, reads the flags, writes the same value back to clear them, reloads the counters and sets the enable again.

Top module: `perf_mon_unit`

## Requirements
- R1: Control bit 0 is a global enable. While it is clear, no counter changes except through a software write or a reset strobe, and all counts and flags are kept.
- R2: Writing control with bit 1 set zeroes all four event counters at that edge. This reset takes priority over a count in the same cycle.
- R3: Writing control with bit 2 set zeroes the cycle counter and its prescaler at that edge. This reset takes priority over a count in the same cycle.
- R4: With control bit 3 set, the cycle counter advances once every 64 enabled cycles. With bit 3 clear, it advances on every enabled cycle.
- R5: Control reads back bit 0 and bit 3 only. Bits 1 and 2 are strobes that read as zero, and bits 4 to 31 read as zero and have no effect when written.
- R6: Event select holds four 8-bit codes: counter k takes bits 8k+7 down to 8k. An enabled counter with code c adds one on every cycle where `evt_i[c]` is high. Event select reads back as written.
- R7: Code 0xFF marks a counter as unused. Such a counter never counts, even when `evt_i[255]` is high.
- R8: All five counters can be read and written at any time. A software write to a counter takes priority over an increment in the same cycle.
- R9: A counter that increments from 0xFFFFFFFF wraps to zero and keeps counting. The wrap sets its overflow flag: bit 0 for the cycle counter, and bit k+1 for event counter k.
- R10: Writing 1 to an overflow flag bit clears that flag, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R11: `irq_o` is high whenever any flag has its matching enable bit set, and it stays high until every such flag is cleared or disabled.
- R12: Interrupt enable uses the overflow-flag bit layout. Its bits 0 to 4 read back as written, and bits above 4 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from `reg_addr_i` |
| evt_i | input | 256 | Event strobes, indexed by event code |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The assertions assume that only one register access happens per cycle and that a counter changes only through a write, a reset strobe or an enabled increment. So they gate their hold and step checks on the write strobe being low. The stimulus drives all inputs on the falling edge and performs every access through single-cycle write tasks. It sweeps each event counter across a range of codes while `evt_i[255]` is held high, so the unused code is exercised every time. It also lines up writes on the exact cycles where a wrap or an increment occurs, to exercise the priority rules.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int A_CTRL  = 0;
  localparam int A_EVSEL = 1;
  localparam int A_IEN   = 2;
  localparam int A_OVF   = 3;
  localparam int A_CYC   = 4;

  localparam int CTRL_EN     = 0;
  localparam int CTRL_RST_EV = 1;
  localparam int CTRL_RST_CY = 2;
  localparam int CTRL_DIV    = 3;
endpackage

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  // wrap only counts when the increment actually lands
  assign wrap_o = inc_i && !clr_i && !wr_i && (&cnt_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pm_prescaler.sv
module pm_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else if (adv_i) pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
  end

  assign tick_o = adv_i && !clr_i && (pre_q == LAST);
endmodule

// File: rtl/pm_event_sel.sv
module pm_event_sel #(
  parameter int CODE_W = 8
) (
  input  logic [2**CODE_W-1:0] evt_i,
  input  logic [CODE_W-1:0]    code_i,
  output logic                 hit_o
);
  // all-ones code parks the counter
  assign hit_o = (code_i != '1) && evt_i[code_i];
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import perf_mon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int N_EVT  = 4,
  parameter int CODE_W = 8,
  parameter int DIV    = 64,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [2**CODE_W-1:0] evt_i,
  output logic                 irq_o
);
  localparam int N_CNT = N_EVT + 1;
  localparam int SEL_W = N_EVT * CODE_W;

  logic                          en_q, div_q;
  logic [SEL_W-1:0]              sel_q;
  logic [N_CNT-1:0]              ien_q, ovf_q;
  logic [N_CNT-1:0][CNT_W-1:0]   cnt_q;
  logic [N_CNT-1:0]              inc, clr, wr, wrap;
  logic                          wr_ctrl, wr_sel, wr_ien, wr_ovf;
  logic                          pre_tick;
  logic [N_CNT-1:0]              ovf_clr;

  assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_W'(A_CTRL));
  assign wr_sel  = reg_we_i && (reg_addr_i == ADDR_W'(A_EVSEL));
  assign wr_ien  = reg_we_i && (reg_addr_i == ADDR_W'(A_IEN));
  assign wr_ovf  = reg_we_i && (reg_addr_i == ADDR_W'(A_OVF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      div_q <= 1'b0;
      sel_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata_i[CTRL_EN];
        div_q <= reg_wdata_i[CTRL_DIV];
      end
      if (wr_sel) sel_q <= reg_wdata_i[SEL_W-1:0];
      if (wr_ien) ien_q <= reg_wdata_i[N_CNT-1:0];
    end
  end

  // cycle counter
  assign clr[0] = wr_ctrl && reg_wdata_i[CTRL_RST_CY];

  pm_prescaler #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr[0]),
    .adv_i (en_q && div_q),
    .tick_o(pre_tick)
  );

  assign inc[0] = en_q && (div_q ? pre_tick : 1'b1);

  // event counters
  for (genvar k = 0; k < N_EVT; k++) begin : g_evt
    logic hit;
    pm_event_sel #(.CODE_W(CODE_W)) u_sel (
      .evt_i (evt_i),
      .code_i(sel_q[k*CODE_W +: CODE_W]),
      .hit_o (hit)
    );
    assign clr[k+1] = wr_ctrl && reg_wdata_i[CTRL_RST_EV];
    assign inc[k+1] = en_q && hit;
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    assign wr[i] = reg_we_i && (reg_addr_i == ADDR_W'(A_CYC + i));
    pm_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr[i]),
      .wr_i   (wr[i]),
      .wdata_i(reg_wdata_i[CNT_W-1:0]),
      .inc_i  (inc[i]),
      .cnt_o  (cnt_q[i]),
      .wrap_o (wrap[i])
    );
  end

  // sticky flags, set beats write-one-to-clear
  assign ovf_clr = wr_ovf ? reg_wdata_i[N_CNT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= '0;
    else         ovf_q <= (ovf_q & ~ovf_clr) | wrap;
  end

  assign irq_o = |(ovf_q & ien_q);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(A_CTRL): begin
        reg_rdata_o[CTRL_EN]  = en_q;
        reg_rdata_o[CTRL_DIV] = div_q;
      end
      ADDR_W'(A_EVSEL): reg_rdata_o[SEL_W-1:0] = sel_q;
      ADDR_W'(A_IEN):   reg_rdata_o[N_CNT-1:0] = ien_q;
      ADDR_W'(A_OVF):   reg_rdata_o[N_CNT-1:0] = ovf_q;
      default: ;
    endcase
    for (int i = 0; i < N_CNT; i++) begin
      if (reg_addr_i == ADDR_W'(A_CYC + i)) reg_rdata_o[CNT_W-1:0] = cnt_q[i];
    end
  end
endmodule

// File: rtl/pm_checker.sv
module pm_checker
  import perf_mon_pkg::*;
#(
  parameter int N_CNT  = 5,
  parameter int CNT_W  = 32,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 4
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        reg_we_i,
  input logic [ADDR_W-1:0]           reg_addr_i,
  input logic                        rst_ev_i,
  input logic                        rst_cy_i,
  input logic                        irq_i,
  input logic                        en_i,
  input logic                        div_i,
  input logic [CODE_W-1:0]           code0_i,
  input logic [N_CNT-1:0]            ovf_i,
  input logic [N_CNT-1:0][CNT_W-1:0] cnt_i
);
  logic wr_ctrl, wr_ovf, wr_ien;
  assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_W'(A_CTRL));
  assign wr_ovf  = reg_we_i && (reg_addr_i == ADDR_W'(A_OVF));
  assign wr_ien  = reg_we_i && (reg_addr_i == ADDR_W'(A_IEN));

  a_r1_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !reg_we_i) |=> $stable(cnt_i));

  a_r2_evt_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && rst_ev_i) |=> (cnt_i[N_CNT-1:1] == '0));

  a_r3_cyc_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && rst_cy_i) |=> (cnt_i[0] == '0));

  a_r4_prescale_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && div_i && !reg_we_i) |=> ((cnt_i[0] - $past(cnt_i[0])) <= CNT_W'(1)));

  a_r7_unused_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && (code0_i == '1)) |=> $stable(cnt_i[1]));

  a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ovf |=> ((ovf_i & $past(ovf_i)) == $past(ovf_i)));

  a_r11_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !wr_ovf && !wr_ien) |=> irq_i);
endmodule

bind perf_mon_unit pm_checker #(
  .N_CNT (N_CNT),
  .CNT_W (CNT_W),
  .CODE_W(CODE_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_we_i  (reg_we_i),
  .reg_addr_i(reg_addr_i),
  .rst_ev_i  (reg_wdata_i[1]),
  .rst_cy_i  (reg_wdata_i[2]),
  .irq_i     (irq_o),
  .en_i      (en_q),
  .div_i     (div_q),
  .code0_i   (sel_q[CODE_W-1:0]),
  .ovf_i     (ovf_q),
  .cnt_i     (cnt_q)
);

// File: tb/perf_mon_unit_tb.sv
module perf_mon_unit_tb;
  localparam int CLK_P = 10;
  localparam logic [3:0] CTRL = 0, EVSEL = 1, IEN = 2, OVF = 3, CYC = 4, EV0 = 5;

  logic         clk = 0;
  logic         rst_n;
  logic         we;
  logic [3:0]   addr;
  logic [31:0]  wdata;
  logic [31:0]  rdata;
  logic [255:0] evt;
  logic         irq;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  perf_mon_unit u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .evt_i      (evt),
    .irq_o      (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 0;
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic irqchk(input string tag, input logic exp);
    #1;
    chk(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [255:0] v, input int n);
    evt = v;
    repeat (n) @(posedge clk);
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]   codes [8];
    logic [255:0] v;
    logic [31:0]  sel;
    codes = '{8'h00, 8'h05, 8'h06, 8'h07, 8'h0A, 8'h0B, 8'h3C, 8'hFE};
    rst_n = 0; we = 0; addr = 0; wdata = 0; evt = '0;
    idle(3);
    rst_n = 1;
    idle(1);

    // reset state
    for (int a = 0; a < 9; a++) rdchk("reset R5 R12", 4'(a), 32'h0);
    rdchk("reset unmapped", 4'hF, 32'h0);
    irqchk("reset R11", 1'b0);

    // R5 control readback
    wr(CTRL, 32'hFFFF_FFF9);
    rdchk("R5 ctrl readback", CTRL, 32'h9);
    wr(CTRL, 32'h6);
    rdchk("R5 strobes read zero", CTRL, 32'h0);
    rdchk("R3 cycle cleared", CYC, 32'h0);
    // R12 / R6 readback
    wr(IEN, 32'hFFFF_FFFF);
    rdchk("R12 ien readback", IEN, 32'h1F);
    wr(IEN, 32'h0);
    wr(EVSEL, 32'h0B0A_0706);
    rdchk("R6 evsel readback", EVSEL, 32'h0B0A_0706);

    // R6 / R7 sweep: counter k on code c, others unused, evt[255] held high
    for (int k = 0; k < 4; k++) begin
      for (int ci = 0; ci < 8; ci++) begin
        int n;
        n = k + ci + 2;
        wr(CTRL, 32'h0);
        sel = 32'hFFFF_FFFF;
        sel[8*k +: 8] = codes[ci];
        wr(EVSEL, sel);
        wr(CTRL, 32'h3);
        v = '0;
        v[codes[ci]] = 1'b1;
        v[255] = 1'b1;
        pulse(v, n);
        wr(CTRL, 32'h0);
        for (int j = 0; j < 4; j++)
          rdchk((j == k) ? "R6 selected count" : "R7 unused stays zero",
                EV0 + 4'(j), (j == k) ? 32'(n) : 32'h0);
        if (ci == 7) begin
          evt = '1;
          idle(10);
          evt = '0;
          rdchk("R1 hold while disabled", EV0 + 4'(k), 32'(n));
        end
      end
    end

    // R4 cycle counter, no prescale then /64
    wr(CTRL, 32'h5); idle(9); wr(CTRL, 32'h0);
    rdchk("R4 every cycle", CYC, 32'd10);
    wr(CTRL, 32'hD); idle(62); wr(CTRL, 32'h0);
    rdchk("R4 div 63 cycles", CYC, 32'd0);
    wr(CTRL, 32'hD); idle(63); wr(CTRL, 32'h0);
    rdchk("R4 div 64 cycles", CYC, 32'd1);
    wr(CTRL, 32'hD); idle(199); wr(CTRL, 32'h0);
    rdchk("R4 div 200 cycles", CYC, 32'd3);
    // R3 prescaler cleared by cycle reset
    wr(CTRL, 32'h4);
    wr(CTRL, 32'h9); idle(39);
    wr(CTRL, 32'hD); idle(62); wr(CTRL, 32'h0);
    rdchk("R3 prescaler cleared", CYC, 32'd0);

    // R9 event overflow, R11 gating
    wr(OVF, 32'hFFFF_FFFF);
    wr(IEN, 32'h0);
    wr(EVSEL, 32'hFF0B_FFFF);
    wr(EV0 + 4'd2, 32'hFFFF_FFFD);
    wr(CTRL, 32'h1);
    v = '0; v[8'h0B] = 1'b1;
    pulse(v, 5);
    wr(CTRL, 32'h0);
    rdchk("R9 wrap continues", EV0 + 4'd2, 32'd2);
    rdchk("R9 flag bit3", OVF, 32'h08);
    irqchk("R11 masked", 1'b0);
    wr(IEN, 32'h08);
    irqchk("R11 enabled", 1'b1);
    wr(IEN, 32'h17);
    irqchk("R11 other enables", 1'b0);
    wr(IEN, 32'h1F);
    // cycle overflow
    wr(CYC, 32'hFFFF_FFF0);
    wr(CTRL, 32'h1); idle(19); wr(CTRL, 32'h0);
    rdchk("R9 cycle wrap", CYC, 32'd4);
    rdchk("R9 flag bit0", OVF, 32'h09);
    // R10 write one to clear
    wr(OVF, 32'h08);
    rdchk("R10 partial clear", OVF, 32'h01);
    irqchk("R11 still pending", 1'b1);
    wr(OVF, 32'h01);
    rdchk("R10 all clear", OVF, 32'h00);
    irqchk("R11 dropped", 1'b0);
    // R10 set beats clear
    wr(EVSEL, 32'hFFFF_FF07);
    wr(EV0, 32'hFFFF_FFFF);
    evt = '0; evt[7] = 1'b1;
    wr(CTRL, 32'h1);
    wr(OVF, 32'h02);
    wr(CTRL, 32'h0);
    evt = '0;
    rdchk("R10 set beats clear", OVF, 32'h02);
    rdchk("R9 counts past wrap", EV0, 32'd1);
    irqchk("R11 set again", 1'b1);
    wr(OVF, 32'h1F);

    // R8 write wins over increment
    evt[7] = 1'b1;
    wr(CTRL, 32'h1); idle(2);
    wr(EV0, 32'd100);
    wr(CTRL, 32'h0);
    rdchk("R8 write wins", EV0, 32'd101);
    // R2 reset wins over count
    wr(CTRL, 32'h1); idle(3);
    wr(CTRL, 32'h3);
    wr(CTRL, 32'h0);
    evt = '0;
    rdchk("R2 reset wins", EV0, 32'd1);
    // R3 reset wins over count
    wr(CTRL, 32'h1); idle(3);
    wr(CTRL, 32'h5);
    wr(CTRL, 32'h0);
    rdchk("R3 reset wins", CYC, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule